// File: doc/BRIEF.md
# Thread-Masked Shared Event Timer

One up-counting timer is shared by all hardware threads of a multithreaded core. Software programs a limit, restarts the count and turns on the interrupt enable. Each time the count meets the limit on a counting cycle, the timer expires and then wraps to zero. On an enabled expiry, every thread selected in a per-thread mask receives a level interrupt. The interrupt stays latched until software writes the control register.

Counting can be tied to core activity. When the halt-qualify control bit is set, the count only moves in cycles where the core's halted input is low. The registers sit behind a plain auxiliary-register port. Reads are combinational from the address, and writes take effect at the clock edge.

Top module: `thread_evt_timer`

## Requirements
- R1: Reset clears the count, limit, control, thread mask and every pending interrupt to 0, so all reads return 0 and `thread_irq_o` is 0.
- R2: Register map: the count is at address 0x21, control at 0x22, limit at 0x23 and the thread mask at 0xFFFFF850. Control bit 0 is the interrupt enable and control bit 1 is the halt qualifier. Control bits 31..2 read as 0, the mask occupies bits 15..0 with bits 31..16 read as 0, and any other address reads 0.
- R3: A counting cycle is any cycle with control bit 1 clear, or any cycle with `halted_i` low. In a counting cycle where the count differs from the limit, the count rises by one. A write to 0x21 loads the written value and takes priority over counting.
- R4: With control bit 1 set and `halted_i` high, the count holds its value.
- R5: A counting cycle in which the count equals the limit is an expiry. After an expiry the count is 0, which gives a period of limit+1 counting cycles.
- R6: An expiry with control bit 0 set ORs the thread mask into the pending vector. Bit n of the mask drives `thread_irq_o[n]`, and threads whose mask bit is clear are not interrupted.
- R7: With control bit 0 clear, expiries raise no interrupt, and the count keeps running under R3/R4.
- R8: A pending bit stays high until any write to 0x22, which clears every pending bit. An enabled expiry in the same cycle as that write is still latched.
- R9: The mask is sampled at the expiry. Writing the mask afterwards neither adds nor removes pending interrupts.
- R10: Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halted_i | input | 1 | Core is halted (gates counting when control bit 1 is set) |
| aux_addr_i | input | 32 | Register address |
| aux_we_i | input | 1 | Write enable |
| aux_wdata_i | input | DATA_W | Write data |
| aux_rdata_o | output | DATA_W | Read data for `aux_addr_i` |
| thread_irq_o | output | NUM_THREADS | Per-thread level interrupts |

## Verification
A wrong count or limit shows on the count readback in the very next cycle. If the compare is wrong, expiry lands on the wrong cycle, and `thread_irq_o` rises one cycle early or late, or not at all. A corrupted mask or a faulty pending latch lights the wrong thread bits at the next enabled expiry. Those bits then stay wrong until the next control write, so a single sample between expiries exposes the fault. Halt gating errors show as count readbacks that move while halted, or that freeze while running.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int AUX_ADDR_W = 32;

  localparam logic [AUX_ADDR_W-1:0] ADR_COUNT = 32'h0000_0021;
  localparam logic [AUX_ADDR_W-1:0] ADR_CTRL  = 32'h0000_0022;
  localparam logic [AUX_ADDR_W-1:0] ADR_LIMIT = 32'h0000_0023;
  localparam logic [AUX_ADDR_W-1:0] ADR_MASK  = 32'hFFFF_F850;

  localparam int CTRL_W      = 2;
  localparam int CTRL_IE_BIT = 0;
  localparam int CTRL_NH_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_CTRL,
    SEL_LIMIT,
    SEL_MASK
  } reg_sel_e;

  // Address decode shared by the write and read paths.
  function automatic reg_sel_e decode_addr(input logic [AUX_ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a == ADR_COUNT)      s = SEL_COUNT;
    else if (a == ADR_CTRL)  s = SEL_CTRL;
    else if (a == ADR_LIMIT) s = SEL_LIMIT;
    else if (a == ADR_MASK)  s = SEL_MASK;
    return s;
  endfunction

  // A cycle counts unless halt qualification is on and the core is halted.
  function automatic logic count_enable(input logic nh_qual, input logic halted);
    return !(nh_qual && halted);
  endfunction

endpackage

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_wr_i,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             nh_qual_i,
  input  logic             halted_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             hit_tick_o
);
  import evt_timer_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic             advance;
  logic             at_limit;

  // Next count: wrap to zero on reaching the limit, else step by one.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim,
    input logic             adv
  );
    logic [CNT_W-1:0] r;
    if (!adv)            r = cur;
    else if (cur == lim) r = '0;
    else                 r = cur + CNT_W'(1);
    return r;
  endfunction

  assign advance    = count_enable(nh_qual_i, halted_i);
  assign at_limit   = (count_q == limit_q);
  assign hit_tick_o = advance && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (cnt_wr_i) begin
      count_q <= wdata_i;
    end else begin
      count_q <= next_count(count_q, limit_q, advance);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
    end else if (lim_wr_i) begin
      limit_q <= wdata_i;
    end
  end

  assign count_o = count_q;
  assign limit_o = limit_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance && !cnt_wr_i && !at_limit) |=> (count_q == $past(count_q) + CNT_W'(1))); // R3
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (count_q == $past(wdata_i))); // R3
  AST_CNT_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nh_qual_i && halted_i && !cnt_wr_i) |=> $stable(count_q)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_tick_o && !cnt_wr_i) |=> (count_q == '0)); // R5

endmodule

// File: rtl/evt_reg_file.sv
module evt_reg_file #(
  parameter int DATA_W      = 32,
  parameter int NUM_THREADS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  evt_timer_pkg::reg_sel_e       sel_i,
  input  logic                          we_i,
  input  logic [evt_timer_pkg::CTRL_W-1:0] ctrl_wdata_i,
  input  logic [NUM_THREADS-1:0]        mask_wdata_i,
  input  logic [DATA_W-1:0]             count_i,
  input  logic [DATA_W-1:0]             limit_i,
  output logic                          ctrl_ie_o,
  output logic                          ctrl_nh_o,
  output logic                          ctrl_wr_o,
  output logic                          mask_wr_o,
  output logic [NUM_THREADS-1:0]        mask_o,
  output logic [DATA_W-1:0]             rdata_o
);
  import evt_timer_pkg::*;

  localparam int CTRL_PAD = DATA_W - CTRL_W;
  localparam int MASK_PAD = DATA_W - NUM_THREADS;

  logic [CTRL_W-1:0]      ctrl_q;
  logic [NUM_THREADS-1:0] mask_q;

  assign ctrl_wr_o = we_i && (sel_i == SEL_CTRL);
  assign mask_wr_o = we_i && (sel_i == SEL_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_o) begin
      ctrl_q <= ctrl_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_wr_o) begin
      mask_q <= mask_wdata_i;
    end
  end

  assign ctrl_ie_o = ctrl_q[CTRL_IE_BIT];
  assign ctrl_nh_o = ctrl_q[CTRL_NH_BIT];
  assign mask_o    = mask_q;

  generate
    if (MASK_PAD > 0) begin : g_mask_pad
      always_comb begin
        unique case (sel_i)
          SEL_COUNT: rdata_o = count_i;
          SEL_LIMIT: rdata_o = limit_i;
          SEL_CTRL:  rdata_o = {{CTRL_PAD{1'b0}}, ctrl_q};
          SEL_MASK:  rdata_o = {{MASK_PAD{1'b0}}, mask_q};
          default:   rdata_o = '0;
        endcase
      end
    end else begin : g_mask_full
      always_comb begin
        unique case (sel_i)
          SEL_COUNT: rdata_o = count_i;
          SEL_LIMIT: rdata_o = limit_i;
          SEL_CTRL:  rdata_o = {{CTRL_PAD{1'b0}}, ctrl_q};
          SEL_MASK:  rdata_o = mask_q;
          default:   rdata_o = '0;
        endcase
      end
    end
  endgenerate

  AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_NONE) |=> ($stable(ctrl_q) && $stable(mask_q))); // R10
  AST_CTRL_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |=> (ctrl_q == $past(ctrl_wdata_i))); // R2

endmodule

// File: rtl/evt_irq_latch.sv
module evt_irq_latch #(
  parameter int NUM_THREADS = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   expire_i,
  input  logic                   clr_i,
  input  logic [NUM_THREADS-1:0] mask_i,
  output logic [NUM_THREADS-1:0] pend_o
);

  logic [NUM_THREADS-1:0] pend_q;
  logic [NUM_THREADS-1:0] pend_d;

  // One flop per thread: clear on a control write, then OR in the fan-out.
  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      assign pend_d[t] = (pend_q[t] && !clr_i) || (expire_i && mask_i[t]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[t] <= 1'b0;
        else         pend_q[t] <= pend_d[t];
      end
    end
  endgenerate

  assign pend_o = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expire_i && !clr_i) |=> $stable(pend_q)); // R8
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> (pend_q == '0)); // R8
  AST_PEND_FANOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !clr_i) |=> (pend_q == ($past(pend_q) | $past(mask_i)))); // R6

endmodule

// File: rtl/thread_evt_timer.sv
module thread_evt_timer #(
  parameter int DATA_W      = 32,
  parameter int NUM_THREADS = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   halted_i,
  input  logic [31:0]            aux_addr_i,
  input  logic                   aux_we_i,
  input  logic [DATA_W-1:0]      aux_wdata_i,
  output logic [DATA_W-1:0]      aux_rdata_o,
  output logic [NUM_THREADS-1:0] thread_irq_o
);
  import evt_timer_pkg::*;

  localparam int CNT_W = DATA_W;

  reg_sel_e               sel;
  logic                   ctrl_ie;
  logic                   ctrl_nh;
  logic                   ctrl_wr;
  logic                   mask_wr;
  logic                   hit_tick;
  logic                   expire;
  logic [NUM_THREADS-1:0] mask;
  logic [CNT_W-1:0]       count;
  logic [CNT_W-1:0]       limit;

  assign sel    = decode_addr(aux_addr_i);
  assign expire = hit_tick && ctrl_ie;

  evt_count_core #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_wr_i   (aux_we_i && sel == SEL_COUNT),
    .lim_wr_i   (aux_we_i && sel == SEL_LIMIT),
    .wdata_i    (aux_wdata_i),
    .nh_qual_i  (ctrl_nh),
    .halted_i   (halted_i),
    .count_o    (count),
    .limit_o    (limit),
    .hit_tick_o (hit_tick)
  );

  evt_reg_file #(.DATA_W(DATA_W), .NUM_THREADS(NUM_THREADS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (sel),
    .we_i         (aux_we_i),
    .ctrl_wdata_i (aux_wdata_i[CTRL_W-1:0]),
    .mask_wdata_i (aux_wdata_i[NUM_THREADS-1:0]),
    .count_i      (count),
    .limit_i      (limit),
    .ctrl_ie_o    (ctrl_ie),
    .ctrl_nh_o    (ctrl_nh),
    .ctrl_wr_o    (ctrl_wr),
    .mask_wr_o    (mask_wr),
    .mask_o       (mask),
    .rdata_o      (aux_rdata_o)
  );

  evt_irq_latch #(.NUM_THREADS(NUM_THREADS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .clr_i    (ctrl_wr),
    .mask_i   (mask),
    .pend_o   (thread_irq_o)
  );

  AST_IE_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_ie && !ctrl_wr) |=> $stable(thread_irq_o)); // R7
  AST_MASK_NO_RETRO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr && !hit_tick && !ctrl_wr) |=> $stable(thread_irq_o)); // R9

endmodule

// File: tb/thread_evt_timer_bench.sv
module thread_evt_timer_bench;
  localparam int NT = 16;
  localparam int DW = 32;
  localparam logic [31:0] A_CNT = 32'h21;
  localparam logic [31:0] A_CTL = 32'h22;
  localparam logic [31:0] A_LIM = 32'h23;
  localparam logic [31:0] A_MSK = 32'hFFFF_F850;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halted = 1'b0;
  logic          we = 1'b0;
  logic [31:0]   addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NT-1:0] irq;

  always #2 clk = ~clk;

  thread_evt_timer #(.DATA_W(DW), .NUM_THREADS(NT)) u_thread_evt_timer (
    .clk_i(clk), .rst_ni(rst_n), .halted_i(halted), .aux_addr_i(addr),
    .aux_we_i(we), .aux_wdata_i(wdata), .aux_rdata_o(rdata), .thread_irq_o(irq)
  );

  // Bench model of the programmed state.
  logic [31:0]   m_cnt, m_lim;
  logic          m_ie, m_nh;
  logic [NT-1:0] m_msk, m_pend;
  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;

  function automatic logic [31:0] exp_read(input logic [31:0] a);
    if (a == A_CNT) return m_cnt;
    if (a == A_LIM) return m_lim;
    if (a == A_CTL) return {30'd0, m_nh, m_ie};
    if (a == A_MSK) return {16'd0, m_msk};
    return 32'd0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // One clock: drive, update the model at the edge, check at the falling edge.
  task automatic tick(input logic w, input logic [31:0] a, input logic [31:0] d,
                      input logic h, input string tag);
    logic adv, hit, ex;
    logic [NT-1:0] n_pend;
    logic [31:0] n_cnt;
    we = w; addr = a; wdata = d; halted = h;
    @(posedge clk);
    adv = !(m_nh && h);
    hit = adv && (m_cnt == m_lim);
    ex  = hit && m_ie;
    n_pend = ((w && a == A_CTL) ? '0 : m_pend) | (ex ? m_msk : '0);
    if (w && a == A_CNT)  n_cnt = d;
    else if (!adv)        n_cnt = m_cnt;
    else if (hit)         n_cnt = 32'd0;
    else                  n_cnt = m_cnt + 32'd1;
    if (w && a == A_LIM) m_lim = d;
    if (w && a == A_CTL) begin m_ie = d[0]; m_nh = d[1]; end
    if (w && a == A_MSK) m_msk = d[NT-1:0];
    m_cnt = n_cnt;
    m_pend = n_pend;
    @(negedge clk);
    check(tag, "irq", {16'd0, irq}, {16'd0, m_pend});
    check(tag, "rdata", rdata, exp_read(a));
    we = 1'b0;
  endtask

  task automatic idle(input int n, input logic [31:0] a, input logic h, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, a, 32'd0, h, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    report();
  end

  initial begin
    logic [31:0] held;
    m_cnt = 0; m_lim = 0; m_ie = 0; m_nh = 0; m_msk = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, read before any edge after release
    addr = A_CNT; #0.5 check("R1", "count", rdata, 32'd0);
    addr = A_CTL; #0.5 check("R1", "ctrl", rdata, 32'd0);
    addr = A_LIM; #0.5 check("R1", "limit", rdata, 32'd0);
    addr = A_MSK; #0.5 check("R1", "mask", rdata, 32'd0);
    check("R1", "irq", {16'd0, irq}, 32'd0);
    @(negedge clk);
    m_cnt = 32'd1; // one counting edge passed while reading (limit 0: wraps)
    m_cnt = 32'd0;
    tick(1'b1, A_CNT, 32'd0, 1'b0, "R1");

    // R2: control readback pads unused bits with zero; unmapped reads 0
    tick(1'b1, A_CTL, 32'hFFFF_FFFC, 1'b0, "R2");
    check("R2", "ctrl_pad", rdata, 32'd0);
    tick(1'b1, A_CTL, 32'hFFFF_FFFF, 1'b1, "R2");
    check("R2", "ctrl_bits", rdata, 32'd3);
    tick(1'b1, A_MSK, 32'hFFFF_1234, 1'b0, "R2");
    check("R2", "mask_pad", rdata, 32'h0000_1234);
    tick(1'b1, A_CTL, 32'd0, 1'b0, "R2");
    idle(1, 32'h24, 1'b0, "R2");
    check("R2", "unmapped_rd", rdata, 32'd0);

    // R10: unmapped writes leave everything intact
    tick(1'b1, 32'h24, 32'hFFFF_FFFF, 1'b0, "R10");
    tick(1'b1, 32'hFFFF_F851, 32'hFFFF_FFFF, 1'b0, "R10");
    tick(1'b1, 32'h20, 32'hFFFF_FFFF, 1'b0, "R10");
    idle(1, A_MSK, 1'b0, "R10");
    check("R10", "mask_kept", rdata, 32'h0000_1234);
    idle(1, A_CTL, 1'b0, "R10");
    check("R10", "ctrl_kept", rdata, 32'd0);

    // R6: arm sequence; threads 0 and 2 only
    tick(1'b1, A_MSK, 32'h0000_0005, 1'b0, "R6");
    tick(1'b1, A_LIM, 32'd3, 1'b0, "R6");
    tick(1'b1, A_CNT, 32'd0, 1'b0, "R6");
    tick(1'b1, A_CTL, 32'd1, 1'b0, "R6");
    idle(4, A_CNT, 1'b0, "R5");
    check("R6", "irq_fanout", {16'd0, irq}, 32'h0000_0005);

    // R8: level held, cleared by a control write
    idle(2, A_CNT, 1'b0, "R8");
    check("R8", "irq_held", {16'd0, irq}, 32'h0000_0005);
    tick(1'b1, A_LIM, 32'd50, 1'b0, "R8");
    tick(1'b1, A_CTL, 32'd1, 1'b0, "R8");
    check("R8", "irq_cleared", {16'd0, irq}, 32'd0);

    // R9: mask written after expiry changes nothing already latched
    tick(1'b1, A_CNT, 32'd48, 1'b0, "R9");
    idle(3, A_CNT, 1'b0, "R9");
    check("R9", "latched", {16'd0, irq}, 32'h0000_0005);
    tick(1'b1, A_MSK, 32'h0000_00A0, 1'b0, "R9");
    idle(3, A_CNT, 1'b0, "R9");
    check("R9", "no_retro", {16'd0, irq}, 32'h0000_0005);

    // R7: enable off -> expiries silent, count still wraps
    tick(1'b1, A_CTL, 32'd0, 1'b0, "R7");
    tick(1'b1, A_LIM, 32'd2, 1'b0, "R7");
    tick(1'b1, A_CNT, 32'd0, 1'b0, "R7");
    idle(10, A_CNT, 1'b0, "R7");
    check("R7", "quiet", {16'd0, irq}, 32'd0);

    // R4: halt qualifier freezes the count while halted
    tick(1'b1, A_LIM, 32'd100, 1'b0, "R4");
    tick(1'b1, A_CTL, 32'd2, 1'b0, "R4");
    idle(3, A_CNT, 1'b0, "R4");
    held = rdata;
    idle(6, A_CNT, 1'b1, "R4");
    check("R4", "frozen", rdata, held);
    idle(2, A_CNT, 1'b0, "R3");
    check("R3", "resumed", rdata, held + 32'd2);

    // R5: limit 0 expires on every counting cycle
    tick(1'b1, A_LIM, 32'd0, 1'b0, "R5");
    tick(1'b1, A_MSK, 32'h0000_8001, 1'b0, "R5");
    tick(1'b1, A_CNT, 32'd0, 1'b0, "R5");
    tick(1'b1, A_CTL, 32'd1, 1'b0, "R5");
    idle(3, A_CNT, 1'b0, "R5");
    check("R5", "lim0_cnt", rdata, 32'd0);

    // Random mix, seeded
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5EED);
    end
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic h;
      op = $urandom_range(0, 19);
      h = ($urandom_range(0, 2) == 0);
      case (op)
        0: tick(1'b1, A_CNT, $urandom_range(0, 6), h, "R3");
        1: tick(1'b1, A_LIM, $urandom_range(0, 7), h, "R5");
        2: tick(1'b1, A_CTL, $urandom, h, "R8");
        3: tick(1'b1, A_MSK, $urandom, h, "R9");
        4: tick(1'b1, 32'h100 + $urandom_range(0, 15), $urandom, h, "R10");
        5: tick(1'b0, A_CTL, 32'd0, h, "R2");
        6: tick(1'b0, A_MSK, 32'd0, h, "R6");
        7: tick(1'b0, A_LIM, 32'd0, h, "R5");
        default: tick(1'b0, A_CNT, 32'd0, h, "R4");
      endcase
    end
    report();
  end

endmodule